// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This unit is the integer adder of a simple RISC execute stage. One adder serves eight operations picked by a 3-bit code. The operations are signed add and subtract that can trap, unsigned add and subtract that never trap, add-immediate in a trapping and a non-trapping form, and signed and unsigned set-less-than. Subtraction adds the inverted second operand with a carry-in of one. The 16-bit immediate is always sign-extended. Overflow is judged from the signs of the operands and the sum. The carry-out plays no part in it.

Each operation is issued with `issue_i`. Its result and overflow flag are registered and show one cycle later. A small two-state trap machine also steps on each issue. The state is `ST_IDLE` (no request) or `ST_TRAP` (`trap_o` high). Two transitions are named:
- `raise`: any state to `ST_TRAP`, taken when a trapping operation is issued and overflows.
- `clear`: any state to `ST_IDLE`, taken otherwise.

So the trap request is a one-cycle pulse. It is paired with the wrapped result of the operation that caused it. Handling the exception is left to the surrounding pipeline.

Top module: `alu_addsub_trap`

## Requirements
- R1: With op code 000 (add) or 001 (addu), the result is A+B modulo 2^32. It appears on `result_o` in the cycle after `issue_i` is high.
- R2: With op code 010 (sub) or 011 (subu), the result is A plus the bit-inverted B plus one, modulo 2^32.
- R3: For add-type operations (000, 001, 110, 111), `ovf_o` is 1 exactly when both addends share a sign and the sum's bit 31 differs from it. Addends of opposite sign never give overflow.
- R4: For subtraction (010, 011), `ovf_o` is 1 exactly when A and B differ in sign and the result's bit 31 differs from A's bit 31.
- R5: A carry out of bit 31 without the sign condition leaves `ovf_o` at 0, for example 0xFFFFFFFF + 1.
- R6: With op code 110 (addi) or 111 (addiu), the second addend is the immediate with bit 15 copied into bits 31..16.
- R7: For op codes 000, 010 and 110, overflow sets `trap_o` high for exactly one cycle, in the cycle after issue. `result_o` still holds the wrapped sum.
- R8: Op codes 001, 011 and 111 never raise `trap_o`, even when `ovf_o` reports overflow.
- R9: Op code 100 (slt) gives 1 when A < B as signed numbers and 0 otherwise. The answer is correct even when A−B overflows.
- R10: Op code 101 (sltu) gives 1 when A < B as unsigned numbers and 0 otherwise. Both compare ops clear `ovf_o`.
- R11: During and after reset, before any issue, `result_o`, `ovf_o` and `trap_o` are 0.
- R12: In a cycle without issue, `result_o` and `ovf_o` keep their values and `trap_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An operation is issued this cycle |
| op_i | input | 3 | Operation code |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand (unused by immediate forms) |
| imm_i | input | 16 | Immediate for add-immediate forms |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |
| trap_o | output | 1 | One-cycle trap request |

## Verification
The trap pulse of one operation can fall in the same cycle as the issue of the next operation. The bench provokes this by issuing a trapping overflow and, in the very next cycle, an unsigned operation that overflows too. It then judges two things: the pulse belongs to the first operation only, and the non-trapping follower does not stretch the pulse even though its own `ovf_o` is 1. A second pairing issues two trapping overflows back to back. That case checks that `trap_o` stays high for two cycles, one cycle for each operation.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_ADDU  = 3'b001,
        OP_SUB   = 3'b010,
        OP_SUBU  = 3'b011,
        OP_SLT   = 3'b100,
        OP_SLTU  = 3'b101,
        OP_ADDI  = 3'b110,
        OP_ADDIU = 3'b111
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } tstate_e;
endpackage

// File: rtl/imm_sext.sv
module imm_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  imm_i,
    output logic [OUT_W-1:0] ext_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ext_o = {{PAD_W{imm_i[IN_W-1]}}, imm_i};
        end else begin : g_none
            assign ext_o = imm_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        // sign rule: like-signed addends, unlike-signed sum
        ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_addsub_trap.sv
module alu_addsub_trap #(
    parameter int DW    = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [2:0]       op_i,
    input  logic [DW-1:0]    src_a_i,
    input  logic [DW-1:0]    src_b_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [DW-1:0]    result_o,
    output logic             ovf_o,
    output logic             trap_o
);
    import addsub_pkg::*;

    localparam int MSB = DW - 1;

    op_e          op;
    tstate_e      state, state_nx;
    logic [DW-1:0] imm_x, operand_b, sum, next_result;
    logic         sub_sel, is_cmp, is_trapping, is_imm;
    logic         carry, ovf_raw, lt_signed, lt_unsigned, next_ovf, trap_hit;

    assign op = op_e'(op_i);

    // operation decode
    always_comb begin
        sub_sel     = 1'b0;
        is_cmp      = 1'b0;
        is_trapping = 1'b0;
        is_imm      = 1'b0;
        unique case (op)
            OP_ADD:   is_trapping = 1'b1;
            OP_ADDU:  ;
            OP_SUB:   begin sub_sel = 1'b1; is_trapping = 1'b1; end
            OP_SUBU:  sub_sel = 1'b1;
            OP_SLT:   begin sub_sel = 1'b1; is_cmp = 1'b1; end
            OP_SLTU:  begin sub_sel = 1'b1; is_cmp = 1'b1; end
            OP_ADDI:  begin is_imm = 1'b1; is_trapping = 1'b1; end
            OP_ADDIU: is_imm = 1'b1;
            default:  ;
        endcase
    end

    imm_sext #(.IN_W(IMM_W), .OUT_W(DW)) u_sext (
        .imm_i (imm_i),
        .ext_o (imm_x)
    );

    assign operand_b = is_imm ? imm_x : src_b_i;

    addsub_core #(.W(DW)) u_core (
        .a_i     (src_a_i),
        .b_i     (operand_b),
        .sub_i   (sub_sel),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf_raw)
    );

    always_comb begin
        lt_signed   = sum[MSB] ^ ovf_raw;
        lt_unsigned = ~carry;
        if (is_cmp)
            next_result = {{(DW-1){1'b0}}, (op == OP_SLT) ? lt_signed : lt_unsigned};
        else
            next_result = sum;
        next_ovf = ~is_cmp & ovf_raw;
        trap_hit = issue_i & is_trapping & ovf_raw;
    end

    // trap machine: next-state
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = trap_hit ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_nx = trap_hit ? ST_TRAP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // trap machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // result and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ovf_o    <= 1'b0;
        end else if (issue_i) begin
            result_o <= next_result;
            ovf_o    <= next_ovf;
        end
    end

    assign trap_o = (state == ST_TRAP);

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($past(issue_i) && ovf_o));

    // R8
    no_unsigned_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == 3'b001 || op_i == 3'b011 || op_i == 3'b111)) |=> !trap_o);

    // R9 R10
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == 3'b100 || op_i == 3'b101)) |=> (result_o[DW-1:1] == '0 && !ovf_o));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(result_o) && $stable(ovf_o) && !trap_o));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == 3'b000 || op_i == 3'b001) && (src_a_i[DW-1] != src_b_i[DW-1]))
        |=> !ovf_o);
endmodule

// File: tb/tb_alu_addsub_trap.sv
`timescale 1ns/1ps
module tb_alu_addsub_trap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  op_i = 3'b000;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        ovf_o;
    logic        trap_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    alu_addsub_trap dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i),
        .result_o(result_o), .ovf_o(ovf_o), .trap_o(trap_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent model from the requirements
    task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, output logic [31:0] res,
                         output logic ovf, output logic trap);
        longint sa, sb, s;
        logic [31:0] bb;
        bb = (op == 3'b110 || op == 3'b111) ? {{16{imm[15]}}, imm} : b;
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        if (op == 3'b010 || op == 3'b011) s = sa - sb;
        else                              s = sa + sb;
        ovf  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        res  = s[31:0];
        trap = ovf && (op == 3'b000 || op == 3'b010 || op == 3'b110);
        if (op == 3'b100) begin res = {31'd0, $signed(a) < $signed(b)}; ovf = 1'b0; trap = 1'b0; end
        if (op == 3'b101) begin res = {31'd0, a < b};                   ovf = 1'b0; trap = 1'b0; end
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] imm);
        logic [31:0] er;
        logic eo, et;
        model(op, a, b, imm, er, eo, et);
        @(negedge clk);
        issue_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b; imm_i = imm;
        @(negedge clk);
        issue_i = 1'b0; src_a_i = ~a; src_b_i = ~b; imm_i = ~imm;
        check({tag, " result"}, result_o, er);
        check({tag, " ovf"}, {31'd0, ovf_o}, {31'd0, eo});
        check({tag, " trap"}, {31'd0, trap_o}, {31'd0, et});
        @(negedge clk);
        check({tag, " R12 hold result"}, result_o, er);
        check({tag, " R12 hold ovf"}, {31'd0, ovf_o}, {31'd0, eo});
        check({tag, " R7 R12 trap low"}, {31'd0, trap_o}, 32'd0);
    endtask

    task automatic test_reset();
        check("R11 result", result_o, 32'd0);
        check("R11 ovf", {31'd0, ovf_o}, 32'd0);
        check("R11 trap", {31'd0, trap_o}, 32'd0);
    endtask

    task automatic test_add();
        run_op("R1 add", 3'b000, 32'd5, 32'd7, 16'h0);
        run_op("R1 addu", 3'b001, 32'h1234_5678, 32'h0fed_cba9, 16'h0);
        run_op("R5 carry only", 3'b000, 32'hFFFF_FFFF, 32'd1, 16'h0);
        run_op("R3 R7 pos+pos", 3'b000, 32'h7FFF_FFFF, 32'd1, 16'h0);
        run_op("R3 R7 neg+neg", 3'b000, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
        run_op("R3 opposite", 3'b000, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        run_op("R8 addu ovf", 3'b001, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0);
    endtask

    task automatic test_sub();
        run_op("R2 sub", 3'b010, 32'd5, 32'd7, 16'h0);
        run_op("R2 subu", 3'b011, 32'd100, 32'd1, 16'h0);
        run_op("R4 R7 neg-pos", 3'b010, 32'h8000_0000, 32'd1, 16'h0);
        run_op("R4 R7 pos-neg", 3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        run_op("R4 same sign", 3'b010, 32'h8000_0000, 32'h8000_0000, 16'h0);
        run_op("R8 subu ovf", 3'b011, 32'h8000_0000, 32'd1, 16'h0);
    endtask

    task automatic test_imm();
        run_op("R6 addi neg", 3'b110, 32'd10, 32'd0, 16'hFFFF);
        run_op("R6 addiu sext", 3'b111, 32'h0001_0000, 32'd0, 16'h8000);
        run_op("R6 addi pos", 3'b110, 32'd3, 32'hDEAD_BEEF, 16'h7FFF);
        run_op("R6 R7 addi ovf", 3'b110, 32'h7FFF_FFFF, 32'd0, 16'h0001);
        run_op("R8 addiu ovf", 3'b111, 32'h8000_0000, 32'd0, 16'hFFFF);
    endtask

    task automatic test_cmp();
        run_op("R9 slt ovf", 3'b100, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        run_op("R10 sltu", 3'b101, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        run_op("R9 slt neg", 3'b100, 32'h8000_0000, 32'd1, 16'h0);
        run_op("R10 sltu big", 3'b101, 32'h8000_0000, 32'd1, 16'h0);
        run_op("R9 slt equal", 3'b100, 32'd42, 32'd42, 16'h0);
        run_op("R10 sltu less", 3'b101, 32'd3, 32'd4, 16'h0);
    endtask

    task automatic test_back_to_back();
        // trapping overflow, then unsigned overflow at once
        @(negedge clk);
        issue_i = 1'b1; op_i = 3'b000; src_a_i = 32'h7FFF_FFFF; src_b_i = 32'd1;
        @(negedge clk);
        op_i = 3'b001; src_a_i = 32'h8000_0000; src_b_i = 32'h8000_0000;
        check("R7 b2b first trap", {31'd0, trap_o}, 32'd1);
        check("R7 b2b first result", result_o, 32'h8000_0000);
        @(negedge clk);
        issue_i = 1'b0;
        check("R8 b2b follower trap", {31'd0, trap_o}, 32'd0);
        check("R8 b2b follower ovf", {31'd0, ovf_o}, 32'd1);
        check("R1 b2b follower result", result_o, 32'd0);
        // two trapping overflows in a row
        @(negedge clk);
        issue_i = 1'b1; op_i = 3'b010; src_a_i = 32'h8000_0000; src_b_i = 32'd1;
        @(negedge clk);
        op_i = 3'b110; src_a_i = 32'h7FFF_FFFF; imm_i = 16'h0001;
        check("R7 b2b trap one", {31'd0, trap_o}, 32'd1);
        @(negedge clk);
        issue_i = 1'b0;
        check("R7 b2b trap two", {31'd0, trap_o}, 32'd1);
        check("R7 b2b wrapped", result_o, 32'h8000_0000);
        @(negedge clk);
        check("R7 b2b trap ends", {31'd0, trap_o}, 32'd0);
    endtask

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_add();
        test_sub();
        test_imm();
        test_cmp();
        test_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule